// File: doc/BRIEF.md
# Smartcard Character Transmitter with NACK Detection and Guard Time

This block sends characters over a single shared smartcard data line. Each accepted byte goes out as a start bit, eight data bits sent least significant bit first, an even parity bit and a stop period one and a half bits long. Timing comes from a 16x oversampling tick. The line is open-drain: the block either pulls it low or lets it go. It never drives it high.

While its own stop period runs, the block reads the line back. This tells it whether the far end is pulling the line low to signal a rejected character. If so, it raises a one-cycle framing error pulse. It then waits for the far end to release the line. The block does not resend the character; the surrounding logic decides whether to retry.

After the last character, the transmit-complete flag stays low for a programmable number of bit times, then rises. The block also outputs a hold signal. A local receiver uses this signal so that it does not take the rejection pulse for the start of a new character.

Top module: `sc_tx_top`

## Requirements
- R1: After reset, `tc` is 1, `tx_ready` is 1, and `frame_err` and `rx_hold` are 0. The line is released (`line_drive_low`=0) and stays released until the first byte is accepted, so no idle frame is sent.
- R2: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. The line is then pulled low for the start bit until the 16th tick after acceptance. Data bits follow, least significant first, 16 ticks each. A data bit of value 0 sets `line_drive_low`=1 and a bit of value 1 releases the line.
- R3: The ninth bit is even parity, equal to the XOR of the eight data bits. It is driven like a data bit.
- R4: The stop period lasts 24 ticks (ticks 161 to 184 after acceptance). The line is released for the whole stop period.
- R5: The line is sampled at the 16th, 17th and 18th ticks of the stop period. If at least two of these three samples are low, `frame_err` pulses for exactly one cycle, right after the 24th stop tick. Otherwise it stays 0.
- R6: `rx_hold` is 1 for the whole stop period and after a detected NACK. It is 0 while the start, data and parity bits are sent.
- R7: After a framing error, the block waits until a tick samples the line high before the guard time starts. Until then, `tx_ready` stays 0 and `rx_hold` stays 1.
- R8: The guard time starts at the end of the stop period, or at the release of the line after a NACK. `tc` stays low for `guard_bits`×16 ticks, then rises within two clock cycles. With `guard_bits`=0, `tc` rises within two cycles of the guard start.
- R9: `tc` drops on the cycle after a byte is accepted. A byte accepted while the guard time runs cancels it, and `tc` stays low until that byte's own guard time ends.
- R10: `tx_ready` is 1 only when the block is idle or in the guard time. It is 0 for the whole character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Block can take a byte |
| guard_bits | input | GW | Guard time in bit times |
| os_tick | input | 1 | One-cycle 16x oversampling tick |
| line_in | input | 1 | Synchronised line level |
| line_drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| rx_hold | output | 1 | Tells a local receiver to ignore the line |
| tc | output | 1 | Transmit complete |
| frame_err | output | 1 | One-cycle pulse when a NACK is seen |

## Verification
Results are due at fixed points. A bit becomes valid on the cycle after the tick that ends the previous bit. `frame_err` follows the 24th stop tick by one register stage, and `tc` follows the last guard tick by two. For this reason, the bench counts ticks from the acceptance edge and samples on the falling clock edge. Line checks sample mid-bit, at tick 16·b+8, so a one-tick slip shows up only as a wrong level at a bit boundary, not as a false failure. Error and `tc` checks are made one to three cycles after the deciding tick, and the bench ticks only every fourth cycle, so no other tick can interfere. NACK patterns are chosen to hit zero, one, two and three of the vote samples, and to extend past the stop period.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

  localparam int SC_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_DRAIN,
    ST_GUARD
  } sc_state_e;

  // value of the parity bit that makes the count of ones even
  function automatic logic even_parity(input logic [SC_DW-1:0] d);
    return ^d;
  endfunction

  // true when at least two of three samples are low
  function automatic logic maj_low3(input logic [2:0] s);
    return (!s[0] && !s[1]) || (!s[0] && !s[2]) || (!s[1] && !s[2]);
  endfunction

  // ticks in a stop period of one and a half bits
  function automatic int stop_ticks(input int osr);
    return osr + osr / 2;
  endfunction

endpackage

// File: rtl/sc_bit_timer.sv
module sc_bit_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] last,
  output logic [CW-1:0] cnt,
  output logic          at_last
);

  assign at_last = tick && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (at_last) cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sc_nack_vote.sv
module sc_nack_vote
  import sc_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sample_en,
  input  logic line,
  output logic vote_low
);

  logic [2:0] smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         smp <= 3'b111;
    else if (clear)     smp <= 3'b111;
    else if (sample_en) smp <= {smp[1:0], line};
  end

  assign vote_low = maj_low3(smp);

endmodule

// File: rtl/sc_guard_timer.sv
module sc_guard_timer #(
  parameter int OSR = 16,
  parameter int GW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  input  logic [GW-1:0] limit,
  output logic          expired
);

  localparam int TW = $clog2(OSR);

  logic [TW-1:0] tcnt;
  logic [GW-1:0] bcnt;

  assign expired = (bcnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      bcnt <= '0;
    end else if (clear) begin
      tcnt <= '0;
      bcnt <= '0;
    end else if (tick && !expired) begin
      if (tcnt == TW'(OSR - 1)) begin
        tcnt <= '0;
        bcnt <= bcnt + 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  AST_GUARD_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clear) |=> $stable(bcnt)); // R8

endmodule

// File: rtl/sc_tx_top.sv
module sc_tx_top
  import sc_tx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int GW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [GW-1:0] guard_bits,
  input  logic          os_tick,
  input  logic          line_in,
  output logic          line_drive_low,
  output logic          rx_hold,
  output logic          tc,
  output logic          frame_err
);

  localparam int STOP_T    = stop_ticks(OSR);
  localparam int CW        = $clog2(STOP_T);
  localparam int BW        = $clog2(SC_DW);
  localparam int SMP_FIRST = OSR - 1;

  sc_state_e        state;
  logic [SC_DW-1:0] shreg;
  logic             par_bit;
  logic [BW-1:0]    bidx;

  logic          accept;
  logic [CW-1:0] bit_last;
  logic [CW-1:0] bcnt;
  logic          bit_end;
  logic          sample_en;
  logic          stop_end;
  logic          nack_seen;
  logic          drain_done;
  logic          guard_start;
  logic          guard_done;

  assign tx_ready    = (state == ST_IDLE) || (state == ST_GUARD);
  assign accept      = tx_valid && tx_ready;
  assign bit_last    = (state == ST_STOP) ? CW'(STOP_T - 1) : CW'(OSR - 1);
  assign sample_en   = (state == ST_STOP) && os_tick &&
                       (bcnt >= CW'(SMP_FIRST)) && (bcnt <= CW'(SMP_FIRST + 2));
  assign stop_end    = (state == ST_STOP) && bit_end;
  assign drain_done  = (state == ST_DRAIN) && os_tick && line_in;
  assign guard_start = (stop_end && !nack_seen) || drain_done;

  sc_bit_timer #(.CW(CW)) u_bit (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .tick    (os_tick),
    .last    (bit_last),
    .cnt     (bcnt),
    .at_last (bit_end)
  );

  sc_nack_vote u_vote (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .sample_en (sample_en),
    .line      (line_in),
    .vote_low  (nack_seen)
  );

  sc_guard_timer #(.OSR(OSR), .GW(GW)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (guard_start),
    .tick    (os_tick),
    .limit   (guard_bits),
    .expired (guard_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      par_bit   <= 1'b0;
      bidx      <= '0;
      tc        <= 1'b1;
      frame_err <= 1'b0;
    end else begin
      frame_err <= 1'b0;
      if (accept) begin
        state   <= ST_START;
        shreg   <= tx_data;
        par_bit <= even_parity(tx_data);
        bidx    <= '0;
        tc      <= 1'b0;
      end else begin
        unique case (state)
          ST_START: if (bit_end) state <= ST_DATA;
          ST_DATA: if (bit_end) begin
            if (bidx == BW'(SC_DW - 1)) begin
              state <= ST_PAR;
            end else begin
              bidx  <= bidx + 1'b1;
              shreg <= shreg >> 1;
            end
          end
          ST_PAR: if (bit_end) state <= ST_STOP;
          ST_STOP: if (bit_end) begin
            frame_err <= nack_seen;
            state     <= nack_seen ? ST_DRAIN : ST_GUARD;
          end
          ST_DRAIN: if (drain_done) state <= ST_GUARD;
          ST_GUARD: if (guard_done) begin
            tc    <= 1'b1;
            state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign line_drive_low = (state == ST_START) ||
                          ((state == ST_DATA) && !shreg[0]) ||
                          ((state == ST_PAR) && !par_bit);
  assign rx_hold        = (state == ST_STOP) || (state == ST_DRAIN);

  AST_STOP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP) |-> !line_drive_low); // R4

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err); // R5

  AST_ERR_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($past(state) == ST_STOP) && (state == ST_DRAIN)); // R5

  AST_SAMPLE_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> rx_hold && !line_drive_low); // R6

  AST_DRAIN_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN) |-> !tx_ready && rx_hold); // R7

  AST_TC_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (state == ST_IDLE)); // R8

  AST_TC_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tc && (state == ST_START)); // R9

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !line_drive_low && !rx_hold); // R10

endmodule

// File: tb/sim_sc_tx_top.sv
module sim_sc_tx_top;

  localparam int GW  = 8;
  localparam int DIV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    tx_data = '0;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic [GW-1:0] guard_bits = '0;
  logic          os_tick = 1'b0;
  logic          line_in;
  logic          line_drive_low;
  logic          rx_hold;
  logic          tc;
  logic          frame_err;
  logic          nack_on = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int divc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign line_in = !(line_drive_low || nack_on);

  sc_tx_top #(.OSR(16), .GW(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .guard_bits(guard_bits), .os_tick(os_tick),
    .line_in(line_in), .line_drive_low(line_drive_low), .rx_hold(rx_hold),
    .tc(tc), .frame_err(frame_err)
  );

  always @(posedge clk) begin
    divc <= (divc == DIV - 1) ? 0 : divc + 1;
    os_tick <= (divc == DIV - 2);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!os_tick) @(negedge clk);
  endtask

  // nf..nt: stop-relative ticks whose samples see the line pulled low
  task automatic send(input logic [7:0] d, input int g, input int nf,
                      input int nt, input bit wait_tc);
    int cnt_hit;
    bit err;
    int nmax;
    logic par;
    cnt_hit = 0;
    for (int s = 16; s <= 18; s++) if (s >= nf && s <= nt) cnt_hit++;
    err  = (cnt_hit >= 2);
    nmax = err ? ((161 + nt > 185) ? 161 + nt : 185) : 184;
    par  = ^d;
    guard_bits = GW'(g);
    @(negedge clk);
    chk("R10 ready before accept", int'(tx_ready), 1);
    tx_data  = d;
    tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R9 tc low after accept", int'(tc), 0);
    for (int n = 1; n <= nmax; n++) begin
      int s;
      int b;
      wait_tick();
      s = n - 160;
      b = (n - 1) / 16;
      nack_on = (s >= nf) && (s <= nt);
      if (n % 16 == 8 && b <= 11) begin
        if (b == 0)      chk("R2 start bit", int'(line_drive_low), 1);
        else if (b <= 8) chk("R2 data bit", int'(line_drive_low), int'(!d[b-1]));
        else if (b == 9) chk("R3 parity bit", int'(line_drive_low), int'(!par));
        else             chk("R4 stop released", int'(line_drive_low), 0);
      end
      if (n == 80) begin
        chk("R10 ready low in frame", int'(tx_ready), 0);
        chk("R6 hold low in data", int'(rx_hold), 0);
        chk("R8 tc low in frame", int'(tc), 0);
      end
      if (n == 161 || n == 184) chk("R6 hold in stop", int'(rx_hold), 1);
      if (n == 186 && err && nt >= 27) begin
        chk("R7 ready low in drain", int'(tx_ready), 0);
        chk("R7 hold in drain", int'(rx_hold), 1);
      end
      if (n == 184) begin
        @(posedge clk);
        @(negedge clk);
        chk("R5 error pulse", int'(frame_err), int'(err));
        @(negedge clk);
        chk("R5 error one cycle", int'(frame_err), 0);
      end
    end
    nack_on = 1'b0;
    if (wait_tc) begin
      for (int n = nmax + 1; n <= nmax + 16 * g; n++) begin
        wait_tick();
        if (n == nmax + 16 * g) chk("R8 tc low before guard end", int'(tc), 0);
      end
      repeat (3) @(negedge clk);
      chk("R8 tc high after guard", int'(tc), 1);
      chk("R10 ready in idle", int'(tx_ready), 1);
    end
  endtask

  int pat_nf[6] = '{99, 16, 17, 9, 9, 5};
  int pat_nt[6] = '{0, 16, 18, 24, 40, 15};

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tc at reset", int'(tc), 1);
    chk("R1 ready at reset", int'(tx_ready), 1);
    chk("R1 err at reset", int'(frame_err), 0);
    rst_n = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (line_drive_low || rx_hold) seen++;
      end
      chk("R1 no idle frame", seen, 0);
    end
    for (int i = 0; i < 24; i++) begin
      logic [7:0] d;
      d = 8'(i * 37 + 5) ^ 8'(i << 4);
      if (i == 0) d = 8'h00;
      if (i == 1) d = 8'hFF;
      send(d, i % 4, pat_nf[i % 6], pat_nt[i % 6], 1'b1);
    end
    send(8'hA5, 3, 99, 0, 1'b0);
    repeat (40) wait_tick();
    chk("R9 tc low mid guard", int'(tc), 0);
    send(8'h3C, 1, 99, 0, 1'b1);
    send(8'h81, 0, 9, 40, 1'b1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule